// File: doc/BRIEF.md
# Destination Routing Table with Indirect Register Access

This block holds the destination-ID routing tables of a 16-port packet switch. Every ingress port owns a table that maps a destination ID to an egress port. Each ingress port looks up its own table combinationally. Software never addresses a table entry directly. It first writes an index into a select register. It then reads or writes the entry at that index through the data register paired with it.

There is one register pair per port, which reaches only that port's table. A broadcast pair writes the selected entry of every port's table in the same cycle. Setting bit 31 in a select write enters a bulk mode. In bulk mode each data write advances the index, so a run of data writes fills a whole table. A mode register carries one flag that disables port-write event generation on every port at once.

Top module: `rt_route_lut`

## Requirements
- R1: After reset, every entry of every table reads back as 0xFF, every lookup reports invalid, and `pw_en_o` is all ones.
- R2: A write of index I to port n's select register (0x11070 + 0x100*n), followed by a write of V (0..15) to its data register (0x11074 + 0x100*n), stores V. A later read of the data register with index I returns V.
- R3: A write through port n's pair changes only port n's table. Lookups of the same ID on other ports keep their previous result.
- R4: A data write through the broadcast pair (select 0x10070, data 0x10074) stores the value at the broadcast index in all tables. All lookups reflect it in the cycle after the write. A read of the broadcast data register returns port 0's copy.
- R5: A written port value above 15 (data bits 7:0) is stored as invalid and reads back as 0xFF. The value 15 is stored as-is.
- R6: A select write with bit 31 set enters bulk mode with the index from the low bits. Each data write then stores at the current index and advances it by one, wrapping from the last entry (255 for 256 entries) to 0.
- R7: A select write with bit 31 clear leaves bulk mode. Later data writes all store to the same index.
- R8: The mode register (0x10004) stores only bit 27; its other bits read 0. While bit 27 is 1, `pw_en_o` is all zeros from the cycle after the write. Otherwise it is all ones.
- R9: Each ingress port p presents its destination ID on `lkp_dest_i[8p+7:8p]`. In the same cycle it gets the stored port on `lkp_port_o[4p+3:4p]`, with `lkp_valid_o[p]` high. If the entry is invalid, the flag is low and the port field is 0.
- R10: Read data appears on `rdata_o` on the clock edge that samples `rd_en_i`. Unmapped addresses read 0, and writes to them change nothing.
- R11: A select register reads back as bit 31 = bulk flag and the low bits = current index, which shows the advance made by bulk writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 32 | Register byte address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data, registered |
| lkp_dest_i | input | 128 | Per-port destination ID for lookup, 8 bits per port |
| lkp_port_o | output | 64 | Per-port egress port result, 4 bits per port |
| lkp_valid_o | output | 16 | Per-port route-valid flag |
| pw_en_o | output | 16 | Per-port port-write generation enable |

## Verification
The table is exercised with single per-port writes, broadcast writes, and bulk fills that cross the wrap point. This separates a per-port copy from shared storage and a wrapping index from a saturating one. Port values of 15, 16 and 0x20 test the invalid encoding at its edge. Lookup IDs are randomized on every clock against a behavioural model, so any stray write to the wrong table or the wrong index shows up. Writes to unmapped and out-of-range port addresses confirm that the decode ignores them.

// File: rtl/rt_pkg.sv
package rt_pkg;
  localparam logic [31:0] ADDR_MODE   = 32'h0001_0004;
  localparam logic [31:0] ADDR_BC_SEL = 32'h0001_0070;
  localparam logic [31:0] ADDR_BC_DAT = 32'h0001_0074;
  localparam logic [31:0] PP_SEL_BASE = 32'h0001_1070;
  localparam logic [31:0] PP_DAT_BASE = 32'h0001_1074;
  localparam logic [31:0] PP_STRIDE   = 32'h0000_0100;
  localparam int          PW_DIS_BIT  = 27;
  localparam int          BULK_BIT    = 31;
  localparam logic [7:0]  RT_INVALID  = 8'hFF;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_MODE,
    ACC_BC_SEL,
    ACC_BC_DAT,
    ACC_PP_SEL,
    ACC_PP_DAT
  } acc_e;
endpackage

// File: rtl/rt_decode.sv
module rt_decode
  import rt_pkg::*;
#(
  parameter int NP = 16,
  parameter int PW = 4
) (
  input  logic [31:0]   addr_i,
  output acc_e          kind_o,
  output logic [PW-1:0] port_o
);
  always_comb begin
    kind_o = ACC_NONE;
    port_o = '0;
    if (addr_i == ADDR_MODE)        kind_o = ACC_MODE;
    else if (addr_i == ADDR_BC_SEL) kind_o = ACC_BC_SEL;
    else if (addr_i == ADDR_BC_DAT) kind_o = ACC_BC_DAT;
    else begin
      for (int n = 0; n < NP; n++) begin
        if (addr_i == PP_SEL_BASE + PP_STRIDE * 32'(n)) begin
          kind_o = ACC_PP_SEL;
          port_o = PW'(n);
        end
        if (addr_i == PP_DAT_BASE + PP_STRIDE * 32'(n)) begin
          kind_o = ACC_PP_DAT;
          port_o = PW'(n);
        end
      end
    end
  end
endmodule

// File: rtl/rt_sel.sv
module rt_sel
  import rt_pkg::*;
#(
  parameter int IDW = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           sel_wr_i,
  input  logic           dat_wr_i,
  input  logic [31:0]    wdata_i,
  output logic [IDW-1:0] idx_o,
  output logic           bulk_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o  <= '0;
      bulk_o <= 1'b0;
    end else if (sel_wr_i) begin
      idx_o  <= wdata_i[IDW-1:0];
      bulk_o <= wdata_i[BULK_BIT];
    end else if (dat_wr_i && bulk_o) begin
      idx_o <= idx_o + 1'b1; // natural wrap at table end
    end
  end

  p_bulk_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_wr_i && bulk_o && !sel_wr_i) |=> (idx_o == IDW'($past(idx_o) + 1'b1)));

  p_hold_idx_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bulk_o && !sel_wr_i) |=> $stable(idx_o));

  p_sel_load_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_wr_i |=> (idx_o == $past(wdata_i[IDW-1:0])) && (bulk_o == $past(wdata_i[BULK_BIT])));
endmodule

// File: rtl/rt_table.sv
module rt_table
  import rt_pkg::*;
#(
  parameter int NP  = 16,
  parameter int PW  = 4,
  parameter int IDW = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_i,
  input  logic [IDW-1:0] wr_idx_i,
  input  logic [7:0]     wr_val_i,
  input  logic [IDW-1:0] rd_idx_i,
  output logic [7:0]     rd_val_o,
  input  logic [IDW-1:0] lkp_idx_i,
  output logic [PW-1:0]  lkp_port_o,
  output logic           lkp_valid_o
);
  localparam int DEPTH = 1 << IDW;

  // entry = {valid, port}; any value >= NP collapses to invalid
  logic [PW:0] mem [DEPTH];
  logic        wr_ok;
  logic [PW:0] rd_ent;
  logic [PW:0] lk_ent;

  assign wr_ok = (wr_val_i < 8'(NP));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_i) begin
      mem[wr_idx_i] <= {wr_ok, wr_ok ? wr_val_i[PW-1:0] : {PW{1'b0}}};
    end
  end

  assign rd_ent      = mem[rd_idx_i];
  assign lk_ent      = mem[lkp_idx_i];
  assign rd_val_o    = rd_ent[PW] ? 8'(rd_ent[PW-1:0]) : RT_INVALID;
  assign lkp_valid_o = lk_ent[PW];
  assign lkp_port_o  = lk_ent[PW] ? lk_ent[PW-1:0] : '0;

  p_wr_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (rd_idx_i != $past(wr_idx_i)) ||
             (rd_val_o == (($past(wr_val_i) < 8'(NP)) ? $past(wr_val_i) : RT_INVALID)));
endmodule

// File: rtl/rt_route_lut.sv
module rt_route_lut
  import rt_pkg::*;
#(
  parameter int NUM_PORTS = 16,
  parameter bit LARGE_SYS = 1'b0
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic                          rd_en_i,
  input  logic [31:0]                   addr_i,
  input  logic [31:0]                   wdata_i,
  output logic [31:0]                   rdata_o,
  input  logic [NUM_PORTS*(LARGE_SYS ? 9 : 8)-1:0] lkp_dest_i,
  output logic [NUM_PORTS*$clog2(NUM_PORTS)-1:0]   lkp_port_o,
  output logic [NUM_PORTS-1:0]          lkp_valid_o,
  output logic [NUM_PORTS-1:0]          pw_en_o
);
  localparam int NP  = NUM_PORTS;
  localparam int IDW = LARGE_SYS ? 9 : 8;
  localparam int PW  = $clog2(NUM_PORTS);

  acc_e          kind;
  logic [PW-1:0] dport;

  rt_decode #(.NP(NP), .PW(PW)) u_dec (
    .addr_i (addr_i),
    .kind_o (kind),
    .port_o (dport)
  );

  logic           bc_sel_wr, bc_dat_wr;
  logic [IDW-1:0] bc_idx;
  logic           bc_bulk;
  logic           pw_dis;

  assign bc_sel_wr = wr_en_i && (kind == ACC_BC_SEL);
  assign bc_dat_wr = wr_en_i && (kind == ACC_BC_DAT);

  rt_sel #(.IDW(IDW)) u_bc_sel (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_wr_i (bc_sel_wr),
    .dat_wr_i (bc_dat_wr),
    .wdata_i  (wdata_i),
    .idx_o    (bc_idx),
    .bulk_o   (bc_bulk)
  );

  logic [IDW-1:0] pp_idx  [NP];
  logic           pp_bulk [NP];
  logic [7:0]     rd_val  [NP];

  for (genvar n = 0; n < NP; n++) begin : g_port
    logic           sel_wr, dat_wr, t_wr;
    logic [IDW-1:0] t_wr_idx, t_rd_idx;

    assign sel_wr   = wr_en_i && (kind == ACC_PP_SEL) && (dport == PW'(n));
    assign dat_wr   = wr_en_i && (kind == ACC_PP_DAT) && (dport == PW'(n));
    assign t_wr     = bc_dat_wr || dat_wr;
    assign t_wr_idx = bc_dat_wr ? bc_idx : pp_idx[n];
    assign t_rd_idx = (kind == ACC_BC_DAT) ? bc_idx : pp_idx[n];

    rt_sel #(.IDW(IDW)) u_sel (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sel_wr_i (sel_wr),
      .dat_wr_i (dat_wr),
      .wdata_i  (wdata_i),
      .idx_o    (pp_idx[n]),
      .bulk_o   (pp_bulk[n])
    );

    rt_table #(.NP(NP), .PW(PW), .IDW(IDW)) u_tbl (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_i        (t_wr),
      .wr_idx_i    (t_wr_idx),
      .wr_val_i    (wdata_i[7:0]),
      .rd_idx_i    (t_rd_idx),
      .rd_val_o    (rd_val[n]),
      .lkp_idx_i   (lkp_dest_i[n*IDW +: IDW]),
      .lkp_port_o  (lkp_port_o[n*PW +: PW]),
      .lkp_valid_o (lkp_valid_o[n])
    );

    assign pw_en_o[n] = !pw_dis;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pw_dis <= 1'b0;
    else if (wr_en_i && (kind == ACC_MODE)) pw_dis <= wdata_i[PW_DIS_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
    end else if (rd_en_i) begin
      unique case (kind)
        ACC_MODE:   rdata_o <= 32'(pw_dis) << PW_DIS_BIT;
        ACC_BC_SEL: rdata_o <= {bc_bulk, {(31-IDW){1'b0}}, bc_idx};
        ACC_BC_DAT: rdata_o <= 32'(rd_val[0]);
        ACC_PP_SEL: rdata_o <= {pp_bulk[dport], {(31-IDW){1'b0}}, pp_idx[dport]};
        ACC_PP_DAT: rdata_o <= 32'(rd_val[dport]);
        default:    rdata_o <= '0;
      endcase
    end
  end

  p_pw_mode_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (kind == ACC_MODE)) |=>
      (pw_en_o == ($past(wdata_i[PW_DIS_BIT]) ? {NP{1'b0}} : {NP{1'b1}})));

  p_unmapped_rd_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (kind == ACC_NONE)) |=> (rdata_o == 32'h0));

  p_bcast_all_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bc_dat_wr && (lkp_dest_i[(NP-1)*IDW +: IDW] == bc_idx) &&
     (wdata_i[7:0] < 8'(NP))) |=>
      ($past(lkp_dest_i[(NP-1)*IDW +: IDW]) != lkp_dest_i[(NP-1)*IDW +: IDW]) ||
      lkp_valid_o[NP-1]);
endmodule

// File: tb/tb_rt_route_lut.sv
module tb_rt_route_lut;
  localparam int NP    = 16;
  localparam int IDW   = 8;
  localparam int DEPTH = 256;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0]       addr = '0, wdata = '0;
  logic [31:0]       rdata;
  logic [NP*IDW-1:0] lkp_dest = '0;
  logic [NP*4-1:0]   lkp_port;
  logic [NP-1:0]     lkp_valid;
  logic [NP-1:0]     pw_en;

  always #4 clk = ~clk; // 125 MHz

  rt_route_lut #(.NUM_PORTS(NP), .LARGE_SYS(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .lkp_dest_i(lkp_dest), .lkp_port_o(lkp_port), .lkp_valid_o(lkp_valid),
    .pw_en_o(pw_en)
  );

  int errors = 0, checks = 0;
  bit running = 1'b0;
  bit finished = 1'b0;

  // behavioural model
  int tbl [NP][DEPTH];
  int bc_i = 0; bit bc_b = 0;
  int pp_i [NP]; bit pp_b [NP];
  bit m_pwdis = 0;

  // lookup stimulus
  bit pin = 0;
  logic [NP*IDW-1:0] pin_val = '0;

  function automatic int norm(int v);
    return (v > 15) ? 255 : v;
  endfunction

  function automatic int sel_addr(int n); return 32'h11070 + 32'h100 * n; endfunction
  function automatic int dat_addr(int n); return 32'h11074 + 32'h100 * n; endfunction

  task automatic model_write(input logic [31:0] a, input logic [31:0] d);
    if (a == 32'h10004) m_pwdis = d[27];
    else if (a == 32'h10070) begin bc_i = int'(d[7:0]); bc_b = d[31]; end
    else if (a == 32'h10074) begin
      for (int p = 0; p < NP; p++) tbl[p][bc_i] = norm(int'(d[7:0]));
      if (bc_b) bc_i = (bc_i + 1) % DEPTH;
    end else begin
      for (int n = 0; n < NP; n++) begin
        if (a == sel_addr(n)) begin pp_i[n] = int'(d[7:0]); pp_b[n] = d[31]; end
        if (a == dat_addr(n)) begin
          tbl[n][pp_i[n]] = norm(int'(d[7:0]));
          if (pp_b[n]) pp_i[n] = (pp_i[n] + 1) % DEPTH;
        end
      end
    end
  endtask

  function automatic logic [31:0] model_read(input logic [31:0] a);
    if (a == 32'h10004) return {4'b0, m_pwdis, 27'b0};
    if (a == 32'h10070) return {bc_b, 23'b0, 8'(bc_i)};
    if (a == 32'h10074) return 32'(tbl[0][bc_i]);
    for (int n = 0; n < NP; n++) begin
      if (a == sel_addr(n)) return {pp_b[n], 23'b0, 8'(pp_i[n])};
      if (a == dat_addr(n)) return 32'(tbl[n][pp_i[n]]);
    end
    return 32'h0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // entered at a negedge, leaves at the next negedge
  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 model_write(a, d);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input string req, input logic [31:0] a);
    logic [31:0] e;
    e = model_read(a);
    rd_en = 1'b1; addr = a;
    @(posedge clk); #1 chk(req, rdata, e);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pin_all(input int id);
    pin = 1;
    for (int p = 0; p < NP; p++) pin_val[p*IDW +: IDW] = IDW'(id);
  endtask

  // lookup IDs: random unless pinned
  always @(negedge clk) begin
    #1;
    if (pin) lkp_dest = pin_val;
    else for (int p = 0; p < NP; p++) lkp_dest[p*IDW +: IDW] = IDW'($urandom_range(0, DEPTH-1));
  end

  // per-clock comparison of lookups (R9) and pw enables (R8)
  always @(posedge clk) begin
    #3;
    if (running) begin
      for (int p = 0; p < NP; p++) begin
        int e;
        e = tbl[p][int'(lkp_dest[p*IDW +: IDW])];
        chk("R9 lookup valid", 32'(lkp_valid[p]), 32'(e < 16));
        chk("R9 lookup port", 32'(lkp_port[p*4 +: 4]), (e < 16) ? 32'(e) : 32'h0);
      end
      chk("R8 pw enable", 32'(pw_en), m_pwdis ? 32'h0 : 32'hFFFF);
    end
  end

  initial begin
    for (int p = 0; p < NP; p++) begin
      pp_i[p] = 0; pp_b[p] = 0;
      for (int i = 0; i < DEPTH; i++) tbl[p][i] = 255;
    end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    running = 1'b1;

    // R1 reset state
    chk("R1 pw_en after reset", 32'(pw_en), 32'hFFFF);
    rd("R1 port0 entry0", dat_addr(0));
    wr(sel_addr(5), 32'hFF);
    rd("R1 port5 entry255", dat_addr(5));

    // R2 / R3 per-port write
    pin_all(8'h10);
    wr(sel_addr(2), 32'h10);
    wr(dat_addr(2), 32'h7);
    rd("R2 port2 readback", dat_addr(2));
    #1;
    chk("R3 port3 untouched", 32'(lkp_valid[3]), 32'h0);
    chk("R3 port2 updated", 32'(lkp_port[2*4 +: 4]), 32'h7);

    // R5 invalid encoding edges
    wr(sel_addr(2), 32'h11); wr(dat_addr(2), 32'h20);
    rd("R5 0x20 reads invalid", dat_addr(2));
    wr(dat_addr(2), 32'h0F);
    rd("R5 15 stays valid", dat_addr(2));
    wr(dat_addr(2), 32'h10);
    rd("R5 16 reads invalid", dat_addr(2));

    // R4 broadcast
    pin_all(8'h40);
    wr(32'h10070, 32'h40);
    wr(32'h10074, 32'h9);
    #1;
    for (int p = 0; p < NP; p++) chk("R4 broadcast lookup", 32'(lkp_port[p*4 +: 4]), 32'h9);
    @(negedge clk);
    rd("R4 broadcast data read", 32'h10074);
    wr(sel_addr(7), 32'h40);
    rd("R4 port7 copy", dat_addr(7));
    pin = 0;

    // R6 / R11 bulk with wrap
    wr(sel_addr(3), 32'h8000_00FE);
    for (int k = 1; k <= 4; k++) wr(dat_addr(3), 32'(k));
    rd("R11 select after wrap", sel_addr(3));
    wr(sel_addr(3), 32'hFF);
    rd("R6 entry 0xFF", dat_addr(3));
    wr(sel_addr(3), 32'h01);
    rd("R6 entry 0x01 after wrap", dat_addr(3));

    // R7 leave bulk
    wr(sel_addr(3), 32'h05);
    wr(dat_addr(3), 32'd11);
    wr(dat_addr(3), 32'd12);
    rd("R7 index held", sel_addr(3));
    rd("R7 last value", dat_addr(3));

    // R6 full broadcast bulk fill
    wr(32'h10070, 32'h8000_0000);
    for (int k = 0; k < DEPTH; k++) wr(32'h10074, 32'(k % 20));
    rd("R6 broadcast index wrapped", 32'h10070);
    wr(sel_addr(9), 32'd17);
    rd("R6 fill value port9", dat_addr(9));

    // R8 mode register
    rd("R8 mode reset", 32'h10004);
    wr(32'h10004, 32'h0800_00F0);
    rd("R8 mode readback", 32'h10004);
    wr(32'h10004, 32'h0);
    rd("R8 mode cleared", 32'h10004);

    // R10 unmapped
    wr(32'h10078, 32'h3);
    wr(dat_addr(16), 32'h3);
    wr(sel_addr(16), 32'h8000_0001);
    rd("R10 unmapped read", 32'h10078);
    rd("R10 beyond-port read", dat_addr(16));
    rd("R10 tables untouched", dat_addr(9));

    repeat (20) @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule